// File: doc/BRIEF.md
# Memory-Mapped GPIO with Edge Capture

A parallel I/O port of up to 32 pins, reached through four word registers on a simple 32-bit register bus. Each pin has a direction bit, an output latch and a synchronized input readback path. Software can sample pin levels, drive pins configured as outputs, and mark individual pins as interrupt sources.

Every input pin passes through a two-flop synchronizer and an edge detector. Edges of the polarity chosen at build time set sticky capture bits. Software clears a capture bit by writing a one to it. One registered interrupt line combines the pins whose mask bits are set. In the edge modes it follows the captured edges. In level-high mode it follows the live synchronized pin levels. The trigger mode is a build parameter and no register can change it.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the direction, mask, capture and output latch registers are all zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R2: Word index 1 (byte offset 0x4) holds the direction register. Bit value 1 makes the pin an output and 0 makes it an input. `pin_oe` equals this register, and it reads back unchanged.
- R3: A write to word index 0 (offset 0x0) loads the output latch, which drives `pin_out`. A read of index 0 returns the synchronized `pin_in` levels.
- R4: Word index 2 (offset 0x8) holds the interrupt mask, where 1 enables the pin. In every register, bits at or above `NPIN` ignore writes and read as zero.
- R5: A read strobe `bus_rd` presents its data on `bus_rdata` with `bus_rvalid` high exactly one cycle later. `bus_rvalid` is low in every other cycle.
- R6: Parameter `TRIG` selects the edge polarity that sets a capture bit: 0 rising, 1 falling, 2 either edge. Value 3 is level-high mode, in which the capture register records rising edges.
- R7: Word index 3 (offset 0xC) reads the capture register. Capture bits stay set until cleared. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An edge that arrives in the same cycle as a clear leaves the bit set.
- R8: When `pin_in` changes before clock edge k, the capture bit is set at edge k+2. In an edge mode, `irq` then rises at edge k+3.
- R9: In the edge modes, `irq` is high in the cycle after any bit of capture AND mask is set. It falls in the cycle after the last such bit is cleared, and it stays low while the mask is zero.
- R10: In level-high mode, `irq` is the registered OR of the synchronized pin levels AND the mask. Set capture bits have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word index of the register (0 data, 1 direction, 2 mask, 3 capture) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_out | output | NPIN | Output latch value |
| pin_oe | output | NPIN | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined registered interrupt |

## Verification
Some properties are checked on every cycle:
- the one-cycle read-valid timing;
- a cleared capture bit having been cleared only by a write of one;
- an edge that coincides with a clear leaving the bit set;
- direction bits changing only on a direction write;
- `irq` staying low while the mask is zero.

Other behaviour can only be shown by the bench's scenarios, which run four instances with the four trigger modes side by side:
- which polarity sets a capture bit in each mode;
- the exact k+2 and k+3 latencies from a pin change;
- the clear-wins-never collision at a chosen cycle;
- level-mode `irq` following the pins while captured edges are ignored.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO port: trigger modes and register word indices.
// Assumes registers are addressed by word index, not by byte address.
package gpio_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam logic [1:0] IDX_DATA = 2'd0;
    localparam logic [1:0] IDX_DIR  = 2'd1;
    localparam logic [1:0] IDX_MASK = 2'd2;
    localparam logic [1:0] IDX_CAPT = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer per pin plus a history flop for edge detection.
// Assumes pins are asynchronous to clk. The outputs are one-cycle edge pulses
// and the synchronized level.
module gpio_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, hist_q;

    // Shift pins through the synchronizer and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~hist_q;
    assign fall  = ~sync_q & hist_q;
endmodule

// File: rtl/gpio_capture.sv
// Sticky per-pin capture register. TRIG picks which edge pulse sets a bit.
// A one in clr clears a bit, and a coincident edge takes priority over the clear.
module gpio_capture
    import gpio_pkg::*;
#(
    parameter int    W    = 12,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cap
);
    logic [W-1:0] hit;
    logic [W-1:0] cap_q;
    logic         unused_edges;

    generate
        if (TRIG == TRIG_FALL) begin : g_fall
            assign hit = fall;
        end else if (TRIG == TRIG_BOTH) begin : g_both
            assign hit = rise | fall;
        end else begin : g_rise
            assign hit = rise;
        end
    endgenerate

    assign unused_edges = ^{rise, fall};

    // Hold captured edges, drop bits written with one, let new edges win.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr) | hit;
    end

    assign cap = cap_q;

    // R7
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & clr)) |=> ((cap_q & $past(hit & clr)) == $past(hit & clr)));

    // R7
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cap_q) & ~cap_q & ~$past(clr)) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Memory-mapped GPIO port with sticky edge capture and one combined interrupt.
// Assumes single-cycle bus strobes and NPIN <= DATA_W. The trigger mode is
// fixed by TRIG. Reads return data one cycle after the strobe.
module gpio_edge_ctrl
    import gpio_pkg::*;
#(
    parameter int    NPIN   = 12,
    parameter int    DATA_W = 32,
    parameter int    ADDR_W = 2,
    parameter trig_e TRIG   = TRIG_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(IDX_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(IDX_DIR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(IDX_MASK);
    localparam logic [ADDR_W-1:0] A_CAPT = ADDR_W'(IDX_CAPT);

    logic [NPIN-1:0]   wpins;
    logic [NPIN-1:0]   out_q, dir_q, mask_q;
    logic [NPIN-1:0]   lvl, rise, fall, clr, cap;
    logic [DATA_W-1:0] rd_word, rdata_q;
    logic              rvalid_q, irq_q, irq_src;

    assign wpins = bus_wdata[NPIN-1:0];

    generate
        if (NPIN < DATA_W) begin : g_spare
            logic unused_wdata;
            assign unused_wdata = ^bus_wdata[DATA_W-1:NPIN];
        end
    endgenerate

    gpio_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    assign clr = (bus_wr && bus_addr == A_CAPT) ? wpins : '0;

    gpio_capture #(.W(NPIN), .TRIG(TRIG)) u_capt (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .clr(clr), .cap(cap)
    );

    // Load the output latch, direction and mask registers on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_DATA) out_q  <= wpins;
            if (bus_addr == A_DIR)  dir_q  <= wpins;
            if (bus_addr == A_MASK) mask_q <= wpins;
        end
    end

    // Select the addressed register and zero-extend it to the bus width.
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            A_DATA:  rd_word[NPIN-1:0] = lvl;
            A_DIR:   rd_word[NPIN-1:0] = dir_q;
            A_MASK:  rd_word[NPIN-1:0] = mask_q;
            default: rd_word[NPIN-1:0] = cap;
        endcase
    end

    // Register read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_word;
        end
    end

    generate
        if (TRIG == TRIG_LEVEL) begin : g_irq_level
            assign irq_src = |(lvl & mask_q);
        end else begin : g_irq_edge
            assign irq_src = |(cap & mask_q);
        end
    endgenerate

    // Register the combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_src;
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign pin_out    = out_q;
    assign pin_oe     = dir_q;
    assign irq        = irq_q;

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && mask_q == '0 && out_q == '0 && !irq_q));

    // R5
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_DIR) |=> $stable(pin_oe));

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_q);
endmodule

// File: tb/gpio_edge_ctrl_test.sv
// Bench: four instances, one per trigger mode, share the bus and the pins.
module gpio_edge_ctrl_test;
    import gpio_pkg::*;

    localparam int NP = 12;
    localparam logic [1:0] W_DATA = 2'd0, W_DIR = 2'd1, W_MASK = 2'd2, W_CAPT = 2'd3;

    // Stimulus table: pins move from V_FROM to V_TO. The expected capture per
    // mode is rise = to&~from, fall = from&~to, both = from^to.
    localparam logic [NP-1:0] V_FROM [6] = '{12'h000, 12'hFFF, 12'h0F0, 12'hA5A, 12'h3C3, 12'h001};
    localparam logic [NP-1:0] V_TO   [6] = '{12'hFFF, 12'h000, 12'h00F, 12'h5A5, 12'h3FF, 12'h800};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [NP-1:0] pins = '0;
    logic [31:0]   rdata [4];
    logic          rvalid [4];
    logic          irqs [4];
    logic [NP-1:0] pout [4];
    logic [NP-1:0] poe [4];
    logic [31:0]   rv [4];
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #10 clk = ~clk;

    for (genvar m = 0; m < 4; m++) begin : g_mode
        gpio_edge_ctrl #(.NPIN(NP), .TRIG(trig_e'(m))) uut (
            .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
            .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata[m]),
            .bus_rvalid(rvalid[m]), .pin_in(pins), .pin_out(pout[m]),
            .pin_oe(poe[m]), .irq(irqs[m])
        );
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        for (int m = 0; m < 4; m++) rv[m] = rdata[m];
        chk("R5 rvalid after read", {31'd0, rvalid[0]}, 32'd1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pin_oe", {20'd0, poe[0]}, 32'd0);
        chk("R1 pin_out", {20'd0, pout[0]}, 32'd0);
        chk("R1 irq", {31'd0, irqs[0]}, 32'd0);
        bus_read(W_DIR);  chk("R1 dir", rv[0], 32'd0);
        bus_read(W_MASK); chk("R1 mask", rv[0], 32'd0);
        bus_read(W_CAPT); chk("R1 capture", rv[0], 32'd0);

        // R2 direction
        bus_write(W_DIR, 32'hFFFF_FFFF);
        chk("R2 pin_oe", {20'd0, poe[0]}, 32'h0000_0FFF);
        bus_read(W_DIR); chk("R2 dir readback", rv[0], 32'h0000_0FFF);

        // R3 output latch and pin readback
        bus_write(W_DATA, 32'hFFFF_FA5A);
        chk("R3 pin_out", {20'd0, pout[0]}, 32'h0000_0A5A);
        pins = 12'h3C5;
        idle(3);
        bus_read(W_DATA); chk("R3 pin readback", rv[0], 32'h0000_03C5);

        // R4 mask with upper bits ignored
        bus_write(W_MASK, 32'hFFFF_F001);
        bus_read(W_MASK); chk("R4 mask upper bits", rv[0], 32'h0000_0001);
        bus_write(W_MASK, 32'h0);

        // R5 valid drops after one cycle
        @(negedge clk);
        chk("R5 rvalid single cycle", {31'd0, rvalid[0]}, 32'd0);

        // R6 table walk over the four modes
        for (int i = 0; i < 6; i++) begin
            pins = V_FROM[i];
            idle(4);
            bus_write(W_CAPT, 32'h0000_0FFF);
            pins = V_TO[i];
            idle(4);
            bus_read(W_CAPT);
            chk("R6 rising capture", rv[0], {20'd0, V_TO[i] & ~V_FROM[i]});
            chk("R6 falling capture", rv[1], {20'd0, V_FROM[i] & ~V_TO[i]});
            chk("R6 both capture", rv[2], {20'd0, V_FROM[i] ^ V_TO[i]});
            chk("R6 level-mode capture", rv[3], {20'd0, V_TO[i] & ~V_FROM[i]});
            chk("R9 masked irq low", {31'd0, irqs[0]}, 32'd0);
        end

        // R7 sticky bits, write-one-to-clear, zero writes ignored
        pins = '0; idle(4);
        bus_write(W_CAPT, 32'h0000_0FFF);
        pins = 12'h001; idle(4);
        pins = 12'h000; idle(4);
        bus_read(W_CAPT); chk("R7 sticky after pin returns", rv[0], 32'h1);
        bus_write(W_CAPT, 32'h0);
        bus_read(W_CAPT); chk("R7 zero write no effect", rv[0], 32'h1);
        bus_write(W_CAPT, 32'h1);
        bus_read(W_CAPT); chk("R7 write one clears", rv[0], 32'h0);

        // R7 edge in the same cycle as the clear
        pins = 12'h001; idle(4);
        pins = 12'h000; idle(4);
        @(negedge clk); pins = 12'h001;
        @(negedge clk);
        bus_write(W_CAPT, 32'h1);
        bus_read(W_CAPT);
        chk("R7 rising edge beats clear", rv[0], 32'h1);
        chk("R7 clear without edge", rv[1], 32'h0);
        chk("R7 both edge beats clear", rv[2], 32'h1);

        // R8 latency, then R9 and R10 interrupt behaviour
        pins = '0; idle(4);
        bus_write(W_CAPT, 32'h0000_0FFF);
        bus_write(W_MASK, 32'h2);
        @(negedge clk); pins = 12'h002;
        idle(3);
        chk("R8 irq not yet at k+2", {31'd0, irqs[0]}, 32'd0);
        chk("R10 level irq at k+2", {31'd0, irqs[3]}, 32'd1);
        @(negedge clk);
        chk("R8 irq at k+3", {31'd0, irqs[0]}, 32'd1);
        chk("R9 both-mode irq", {31'd0, irqs[2]}, 32'd1);
        chk("R9 falling-mode irq quiet", {31'd0, irqs[1]}, 32'd0);
        pins = '0; idle(3);
        bus_read(W_CAPT);
        chk("R10 level mode captured rise", rv[3], 32'h2);
        chk("R10 level irq ignores capture", {31'd0, irqs[3]}, 32'd0);
        bus_write(W_CAPT, 32'h2);
        chk("R9 irq held one cycle after clear", {31'd0, irqs[0]}, 32'd1);
        @(negedge clk);
        chk("R9 irq drops after clear", {31'd0, irqs[0]}, 32'd0);
        bus_write(W_MASK, 32'h0);
        pins = 12'h002; idle(4);
        chk("R10 level irq masked", {31'd0, irqs[3]}, 32'd0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule